// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small fully associative translation buffer. Each entry holds a virtual page tag, a page-table-entry payload and the address space number (ASN) that was current when the entry was written. The payload consists of a physical page number, four read enables and four write enables (one per privilege mode), a fault-on-read flag, a fault-on-write flag and a global flag. A global entry matches in every address space.

Software prepares an entry by writing a 64-bit staging word, selects an address space through a current-ASN register, and then issues one of four maintenance commands on the command port. The commands are: insert, drop every entry, drop every non-global entry, and drop a single address in the current address space. A combinational lookup port reports hit or miss for a tag and returns the matched payload in the same 64-bit packing used to read back the staging word. A parameter builds the instruction-side variant, in which no inserted entry keeps any write permission.

Top module: `asn_tlb`

## Requirements
- R1: After reset, no entry is valid, every lookup misses with `lk_pte` zero, `pte_rdback` reads zero and `cmd_err` is low.
- R2: The 64-bit packing, used by `pte_wr_data`, `pte_rdback` and `lk_pte`, places the physical page number (27 bits) at bits 58:32, the read enables at 11:8, the write enables at 15:12, fault-on-read at bit 1, fault-on-write at bit 2, global at bit 4 and the ASN (7 bits) at 63:57. The ASN is ORed over the page number where the two overlap. A staging write keeps only these payload fields plus a granularity hint at bits 6:5. `pte_rdback` shows the staged payload together with the current ASN in the cycle after the write.
- R3: An insert (`cmd_op`=0) with a zero granularity hint writes an entry from `cmd_tag`, the staged payload and the current ASN. It takes the register values held before that edge, and the entry is visible on the lookup port from the next cycle.
- R4: An insert whose staged granularity hint is non-zero changes no entry, and `cmd_err` is high for exactly the cycle after it.
- R5: A lookup hits when a valid entry has an equal tag and is either global or carries the current ASN. `lk_pte` then packs that entry's payload and its own ASN (the lowest-index entry wins). On a miss, `lk_pte` is zero.
- R6: An insert fills the lowest-index invalid entry. When every entry is valid, it replaces the entry at a round-robin pointer that starts at 0 and advances by one, with wrap, only on such replacements.
- R7: Command `cmd_op`=1 invalidates every entry.
- R8: Command `cmd_op`=2 invalidates every entry whose global flag is clear and keeps the global ones.
- R9: Command `cmd_op`=3 invalidates the entries that a lookup of `cmd_tag` would hit under the current ASN. Non-global entries of other address spaces are not affected.
- R10: With `INSTR_SIDE`=1, every inserted entry has its write enables (bits 15:12 of `lk_pte`) forced to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| asn_wr_en | input | 1 | Load the current-ASN register |
| asn_wr_data | input | 7 | New current ASN |
| pte_wr_en | input | 1 | Load the staging word |
| pte_wr_data | input | 64 | Staging word in the packed layout, hint at 6:5 |
| cmd_valid | input | 1 | Issue a maintenance command |
| cmd_op | input | 2 | 0 insert, 1 drop all, 2 drop non-global, 3 drop one address |
| cmd_tag | input | TAG_W | Tag for insert and single drop |
| cmd_err | output | 1 | Rejected insert, one cycle later |
| lk_tag | input | TAG_W | Lookup tag |
| lk_hit | output | 1 | Lookup hit |
| lk_pte | output | 64 | Matched payload and ASN, packed |
| pte_rdback | output | 64 | Staged payload with current ASN, packed |

## Verification
The bench builds two copies with `ENTRIES`=4 and `TAG_W`=20 that share every input: one data-side copy (`INSTR_SIDE`=0) and one instruction-side copy (`INSTR_SIDE`=1). With only four entries, a handful of inserts fills the array, so round-robin replacement, pointer wrap and the preference for a freed slot over the pointer can all be observed through lookups. Running both variants side by side on the same stimulus isolates the write-enable masking.

// File: rtl/asn_tlb_pkg.sv
package asn_tlb_pkg;

    localparam int PPN_W   = 27;
    localparam int ASN_W   = 7;
    localparam int MODE_W  = 4;
    localparam int GH_W    = 2;

    localparam int PPN_LSB = 32;
    localparam int RD_LSB  = 8;
    localparam int WR_LSB  = 12;
    localparam int FR_BIT  = 1;
    localparam int FW_BIT  = 2;
    localparam int GL_BIT  = 4;
    localparam int GH_LSB  = 5;
    localparam int ASN_LSB = 57;

    typedef enum logic [1:0] {
        OP_INSERT     = 2'd0,
        OP_DROP_ALL   = 2'd1,
        OP_DROP_LOCAL = 2'd2,
        OP_DROP_ONE   = 2'd3
    } tlb_op_e;

    typedef struct packed {
        logic [PPN_W-1:0]  ppn;
        logic [MODE_W-1:0] rd_en;
        logic [MODE_W-1:0] wr_en;
        logic              flt_rd;
        logic              flt_wr;
        logic              glob;
    } pte_t;

    function automatic pte_t unpack_pte(input logic [63:0] w);
        pte_t p;
        p.ppn    = w[PPN_LSB +: PPN_W];
        p.rd_en  = w[RD_LSB +: MODE_W];
        p.wr_en  = w[WR_LSB +: MODE_W];
        p.flt_rd = w[FR_BIT];
        p.flt_wr = w[FW_BIT];
        p.glob   = w[GL_BIT];
        return p;
    endfunction

    function automatic logic [GH_W-1:0] hint_of(input logic [63:0] w);
        return w[GH_LSB +: GH_W];
    endfunction

    function automatic logic [63:0] pack_pte(input pte_t p, input logic [ASN_W-1:0] a);
        logic [63:0] w;
        w = '0;
        w[PPN_LSB +: PPN_W]  = p.ppn;
        w[RD_LSB +: MODE_W]  = p.rd_en;
        w[WR_LSB +: MODE_W]  = p.wr_en;
        w[FR_BIT]            = p.flt_rd;
        w[FW_BIT]            = p.flt_wr;
        w[GL_BIT]            = p.glob;
        w                    = w | (64'(a) << ASN_LSB);
        return w;
    endfunction

endpackage

// File: rtl/asn_tlb_match.sv
module asn_tlb_match
    import asn_tlb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 32,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]            vld,
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
    input  logic [ENTRIES-1:0][ASN_W-1:0] asns,
    input  logic [ENTRIES-1:0]            glob,
    input  logic [ASN_W-1:0]              cur_asn,
    input  logic [TAG_W-1:0]              qtag,
    output logic [ENTRIES-1:0]            match,
    output logic                          any,
    output logic [IDX_W-1:0]              first
);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match[i] = vld[i] && (tags[i] == qtag) && (glob[i] || (asns[i] == cur_asn));
    end

    assign any = |match;

    always_comb begin
        first = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) first = IDX_W'(i);
        end
    end

endmodule

// File: rtl/asn_tlb_victim.sv
module asn_tlb_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] vld,
    input  logic               advance,
    output logic [IDX_W-1:0]   vic_idx
);

    logic [IDX_W-1:0] ptr;
    logic [IDX_W-1:0] free_idx;
    logic             free_found;

    always_comb begin
        free_idx   = '0;
        free_found = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                free_idx   = IDX_W'(i);
                free_found = 1'b1;
            end
        end
    end

    assign vic_idx = free_found ? free_idx : ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (advance && !free_found) begin
            ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
    import asn_tlb_pkg::*;
#(
    parameter int ENTRIES    = 8,
    parameter int TAG_W      = 32,
    parameter bit INSTR_SIDE = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             asn_wr_en,
    input  logic [6:0]       asn_wr_data,
    input  logic             pte_wr_en,
    input  logic [63:0]      pte_wr_data,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [TAG_W-1:0] cmd_tag,
    output logic             cmd_err,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [63:0]      lk_pte,
    output logic [63:0]      pte_rdback
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]            ent_vld;
    logic [ENTRIES-1:0][TAG_W-1:0] ent_tag;
    logic [ENTRIES-1:0][ASN_W-1:0] ent_asn;
    pte_t [ENTRIES-1:0]            ent_pte;
    logic [ENTRIES-1:0]            ent_glob;

    logic [ASN_W-1:0] cur_asn;
    pte_t             stage_pte;
    logic [GH_W-1:0]  stage_gh;
    pte_t             ins_pte;

    logic [ENTRIES-1:0] lk_match, drop_match;
    logic               drop_any;
    logic [IDX_W-1:0]   lk_first, drop_first, vic_idx;

    tlb_op_e op;
    logic    ins_req, ins_ok;

    assign op      = tlb_op_e'(cmd_op);
    assign ins_req = cmd_valid && (op == OP_INSERT);
    assign ins_ok  = ins_req && (stage_gh == '0);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_glob
        assign ent_glob[i] = ent_pte[i].glob;
    end

    always_comb begin
        ins_pte = stage_pte;
        if (INSTR_SIDE) ins_pte.wr_en = '0;
    end

    asn_tlb_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_lookup (
        .vld(ent_vld), .tags(ent_tag), .asns(ent_asn), .glob(ent_glob),
        .cur_asn(cur_asn), .qtag(lk_tag),
        .match(lk_match), .any(lk_hit), .first(lk_first)
    );

    asn_tlb_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_drop (
        .vld(ent_vld), .tags(ent_tag), .asns(ent_asn), .glob(ent_glob),
        .cur_asn(cur_asn), .qtag(cmd_tag),
        .match(drop_match), .any(drop_any), .first(drop_first)
    );

    asn_tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk(clk), .rst(rst), .vld(ent_vld), .advance(ins_ok), .vic_idx(vic_idx)
    );

    assign lk_pte     = lk_hit ? pack_pte(ent_pte[lk_first], ent_asn[lk_first]) : '0;
    assign pte_rdback = pack_pte(stage_pte, cur_asn);

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_vld   <= '0;
            ent_tag   <= '0;
            ent_asn   <= '0;
            ent_pte   <= '0;
            cur_asn   <= '0;
            stage_pte <= '0;
            stage_gh  <= '0;
            cmd_err   <= 1'b0;
        end else begin
            cmd_err <= ins_req && (stage_gh != '0);
            if (asn_wr_en) cur_asn <= asn_wr_data;
            if (pte_wr_en) begin
                stage_pte <= unpack_pte(pte_wr_data);
                stage_gh  <= hint_of(pte_wr_data);
            end
            if (cmd_valid) begin
                unique case (op)
                    OP_INSERT: begin
                        if (ins_ok) begin
                            ent_vld[vic_idx] <= 1'b1;
                            ent_tag[vic_idx] <= cmd_tag;
                            ent_asn[vic_idx] <= cur_asn;
                            ent_pte[vic_idx] <= ins_pte;
                        end
                    end
                    OP_DROP_ALL:   ent_vld <= '0;
                    OP_DROP_LOCAL: ent_vld <= ent_vld & ent_glob;
                    OP_DROP_ONE:   ent_vld <= ent_vld & ~drop_match;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/asn_tlb_chk.sv
module asn_tlb_chk #(
    parameter int TAG_W      = 32,
    parameter bit INSTR_SIDE = 1'b0
) (
    input logic             clk,
    input logic             rst,
    input logic             asn_wr_en,
    input logic             cmd_valid,
    input logic [1:0]       cmd_op,
    input logic [TAG_W-1:0] cmd_tag,
    input logic             cmd_err,
    input logic [TAG_W-1:0] lk_tag,
    input logic             lk_hit,
    input logic [63:0]      lk_pte,
    input logic [1:0]       stage_gh
);

    p_err_cause_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> $past(cmd_valid && cmd_op == 2'd0 && stage_gh != 2'd0));

    p_insert_visible_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd0 && stage_gh == 2'd0 && !asn_wr_en)
        |=> (lk_tag != $past(cmd_tag)) || lk_hit);

    p_miss_zero_r5: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> lk_pte == 64'd0);

    p_drop_all_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd1) |=> !lk_hit);

    p_drop_local_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'd2) |=> (!lk_hit || lk_pte[4]));

    p_drop_one_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(cmd_valid && cmd_op == 2'd3 && !asn_wr_en) && lk_tag == $past(cmd_tag))
        |-> !lk_hit);

    if (INSTR_SIDE) begin : g_iside
        p_no_write_r10: assert property (@(posedge clk) disable iff (rst)
            lk_hit |-> lk_pte[15:12] == 4'd0);
    end

endmodule

bind asn_tlb asn_tlb_chk #(.TAG_W(TAG_W), .INSTR_SIDE(INSTR_SIDE)) u_chk (
    .clk(clk), .rst(rst), .asn_wr_en(asn_wr_en), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_tag(cmd_tag), .cmd_err(cmd_err), .lk_tag(lk_tag),
    .lk_hit(lk_hit), .lk_pte(lk_pte), .stage_gh(stage_gh)
);

// File: tb/asn_tlb_test.sv
`timescale 1ns/1ps
module asn_tlb_test;

    localparam int TW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          asn_wr_en = 1'b0;
    logic [6:0]    asn_wr_data = '0;
    logic          pte_wr_en = 1'b0;
    logic [63:0]   pte_wr_data = '0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = '0;
    logic [TW-1:0] cmd_tag = '0;
    logic [TW-1:0] lk_tag = '0;
    logic          cmd_err, lk_hit, i_err, i_hit;
    logic [63:0]   lk_pte, pte_rdback, i_pte, i_rdback;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    asn_tlb #(.ENTRIES(4), .TAG_W(TW), .INSTR_SIDE(1'b0)) uut (
        .clk(clk), .rst(rst), .asn_wr_en(asn_wr_en), .asn_wr_data(asn_wr_data),
        .pte_wr_en(pte_wr_en), .pte_wr_data(pte_wr_data), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_tag(cmd_tag), .cmd_err(cmd_err), .lk_tag(lk_tag),
        .lk_hit(lk_hit), .lk_pte(lk_pte), .pte_rdback(pte_rdback)
    );

    asn_tlb #(.ENTRIES(4), .TAG_W(TW), .INSTR_SIDE(1'b1)) uut_i (
        .clk(clk), .rst(rst), .asn_wr_en(asn_wr_en), .asn_wr_data(asn_wr_data),
        .pte_wr_en(pte_wr_en), .pte_wr_data(pte_wr_data), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_tag(cmd_tag), .cmd_err(i_err), .lk_tag(lk_tag),
        .lk_hit(i_hit), .lk_pte(i_pte), .pte_rdback(i_rdback)
    );

    localparam logic [TW-1:0] V_TAG  [4] = '{20'h00111, 20'h00222, 20'h00333, 20'h00444};
    localparam logic [26:0]   V_PPN  [4] = '{27'h6000123, 27'h0000456, 27'h1234567, 27'h7FFFFFF};
    localparam logic [3:0]    V_RD   [4] = '{4'h3, 4'hF, 4'h1, 4'h8};
    localparam logic [3:0]    V_WR   [4] = '{4'h5, 4'hA, 4'h0, 4'hC};
    localparam logic          V_GL   [4] = '{1'b0, 1'b1, 1'b0, 1'b0};
    localparam logic [6:0]    V_ASN  [4] = '{7'd1, 7'd2, 7'd1, 7'd3};

    function automatic logic [63:0] mk(input logic [26:0] ppn, input logic [3:0] rd,
                                       input logic [3:0] wr, input logic fr, input logic fw,
                                       input logic g, input logic [1:0] gh);
        return (64'(ppn) << 32) | (64'(rd) << 8) | (64'(wr) << 12) |
               (64'(fr) << 1) | (64'(fw) << 2) | (64'(g) << 4) | (64'(gh) << 5);
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_asn(input logic [6:0] a);
        @(negedge clk); asn_wr_en = 1'b1; asn_wr_data = a;
        @(negedge clk); asn_wr_en = 1'b0;
    endtask

    task automatic stage(input logic [63:0] w);
        @(negedge clk); pte_wr_en = 1'b1; pte_wr_data = w;
        @(negedge clk); pte_wr_en = 1'b0;
    endtask

    task automatic cmd(input logic [1:0] op, input logic [TW-1:0] tag);
        @(negedge clk); cmd_valid = 1'b1; cmd_op = op; cmd_tag = tag;
        @(negedge clk); cmd_valid = 1'b0;
    endtask

    task automatic look(input logic [TW-1:0] tag);
        lk_tag = tag;
        #1;
    endtask

    initial begin
        logic [63:0] w, e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        look(20'h00000);
        chk("R1 hit", 64'(lk_hit), 64'd0);
        chk("R1 pte", lk_pte, 64'd0);
        chk("R1 rdback", pte_rdback, 64'd0);
        chk("R1 err", 64'(cmd_err), 64'd0);

        // R2: staging keeps payload fields, readback adds the current ASN
        set_asn(7'd5);
        w = 64'hA5A5_5A5A_C3C3_3C1F;
        stage(w);
        chk("R2 rdback", pte_rdback, (w & 64'h07FF_FFFF_0000_FF16) | (64'd5 << 57));

        // R3 / R10: table of inserts, each looked up after it lands
        for (int i = 0; i < 4; i++) begin
            set_asn(V_ASN[i]);
            stage(mk(V_PPN[i], V_RD[i], V_WR[i], 1'b1, 1'b0, V_GL[i], 2'd0));
            cmd(2'd0, V_TAG[i]);
            look(V_TAG[i]);
            e = mk(V_PPN[i], V_RD[i], V_WR[i], 1'b1, 1'b0, V_GL[i], 2'd0) | (64'(V_ASN[i]) << 57);
            chk("R3 hit", 64'(lk_hit), 64'd1);
            chk("R3 pte", lk_pte, e);
            chk("R10 iside pte", i_pte, e & ~(64'hF << 12));
        end

        // R5: hit rule over address spaces and global flag
        set_asn(7'd2);
        look(20'h00111); chk("R5 other asn miss", 64'(lk_hit), 64'd0);
        look(20'h00222); chk("R5 own asn hit", 64'(lk_hit), 64'd1);
        set_asn(7'd1);
        look(20'h00222);
        chk("R5 global hit", 64'(lk_hit), 64'd1);
        chk("R5 entry asn", 64'(lk_pte[63:57]), 64'd2);
        look(20'h00999);
        chk("R5 miss", 64'(lk_hit), 64'd0);
        chk("R5 miss pte", lk_pte, 64'd0);

        // R4: non-zero hint rejected
        stage(mk(27'h1, 4'h1, 4'h1, 1'b0, 1'b0, 1'b0, 2'd1));
        cmd(2'd0, 20'h00555);
        chk("R4 err pulse", 64'(cmd_err), 64'd1);
        look(20'h00555); chk("R4 no entry", 64'(lk_hit), 64'd0);
        look(20'h00111); chk("R4 entries kept", 64'(lk_hit), 64'd1);
        @(negedge clk);
        chk("R4 err one cycle", 64'(cmd_err), 64'd0);

        // R6: full array, round robin from entry 0
        stage(mk(27'h42, 4'h2, 4'h2, 1'b0, 1'b0, 1'b0, 2'd0));
        cmd(2'd0, 20'h00666);
        look(20'h00111); chk("R6 rr slot0 replaced", 64'(lk_hit), 64'd0);
        look(20'h00666); chk("R6 new entry", 64'(lk_hit), 64'd1);
        cmd(2'd0, 20'h00777);
        look(20'h00222); chk("R6 rr slot1 replaced", 64'(lk_hit), 64'd0);
        look(20'h00333); chk("R6 slot2 kept", 64'(lk_hit), 64'd1);

        // R9: single drop honours the current ASN
        cmd(2'd3, 20'h00444);
        set_asn(7'd3);
        look(20'h00444); chk("R9 other asn kept", 64'(lk_hit), 64'd1);
        set_asn(7'd1);
        cmd(2'd3, 20'h00333);
        look(20'h00333); chk("R9 dropped", 64'(lk_hit), 64'd0);
        look(20'h00666); chk("R9 neighbour kept", 64'(lk_hit), 64'd1);

        // R6: freed slot preferred, then pointer (now 2) replaces it
        cmd(2'd0, 20'h00888);
        look(20'h00888); chk("R6 free slot insert", 64'(lk_hit), 64'd1);
        cmd(2'd0, 20'h00999);
        look(20'h00888); chk("R6 rr slot2 replaced", 64'(lk_hit), 64'd0);
        look(20'h00777); chk("R6 slot1 kept", 64'(lk_hit), 64'd1);
        set_asn(7'd3);
        look(20'h00444); chk("R6 slot3 kept", 64'(lk_hit), 64'd1);
        set_asn(7'd1);

        // R8: keep global entries only
        stage(mk(27'h77, 4'h4, 4'h4, 1'b0, 1'b1, 1'b1, 2'd0));
        cmd(2'd0, 20'h00AAA);
        cmd(2'd2, 20'h00000);
        look(20'h00AAA); chk("R8 global kept", 64'(lk_hit), 64'd1);
        look(20'h00666); chk("R8 local dropped", 64'(lk_hit), 64'd0);
        look(20'h00999); chk("R8 local dropped b", 64'(lk_hit), 64'd0);

        // R7: drop everything
        cmd(2'd1, 20'h00000);
        look(20'h00AAA); chk("R7 all dropped", 64'(lk_hit), 64'd0);
        chk("R7 iside dropped", 64'(i_hit), 64'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule